// File: doc/BRIEF.md
# Level-2 Interrupt Aggregator with Bypass

This block sits between a set of peripheral interrupt sources and a parent interrupt controller. It takes up to 32 level-sensitive source lines. It groups them onto a small number of parent-facing output lines, and each output is defined by its own membership mask. Software controls the grouped sources through one 32-bit enable word and can read one 32-bit status word. There are no set or clear aliases, so software changes the enable word only by writing all of it.

A few low-numbered sources, such as UART lines, each have a mux gate. When a source's forward bit is set, its raw line goes straight to a dedicated parent output. It then skips the enable and status logic. When the forward bit is clear, the source joins a chosen group like any other source. The group masks, the forward mask, the number of muxed sources and the group that takes un-forwarded mux sources are all elaboration parameters.

The register port takes a one-cycle valid strobe with a write flag, a one-bit word address and a 32-bit data word. Read data appears on the cycle after the request and is held until the next read.

Top module: `l2_irq_aggregator`

## Requirements
- R1: After reset the enable word is zero, the read data is zero and every grouped output is low.
- R2: A write to word address 0 replaces the whole enable word. A later read of address 0 returns the written value ANDed with the connected-bit mask. With the default parameters that mask is 0x00000FF8, or 0x00000FFA when the forward mask is 0x5.
- R3: A read of word address 1 returns, on the next cycle, the source levels present in the request cycle ANDed with the connected-bit mask.
- R4: A write to word address 1 changes nothing: the enable word read afterwards is unchanged.
- R5: Grouped output 0 (default mask 0xEB8, plus any un-forwarded mux source) is high one clock after a cycle in which some source in its mask is high with its enable bit set. It is low one clock after a cycle in which no such source exists.
- R6: Grouped output 1 (default mask 0x140, sources 6 and 8) follows the same one-clock rule over its own mask.
- R7: For a mux source i whose forward bit is set (default forward mask 0x7, sources 0 to 2), direct output i equals source line i in the same cycle, whatever the enable word holds, and status bit i reads 0.
- R8: Source bits 12 to 31 are unconnected. Their status bits read 0, and their enable bits have no effect on any output.
- R9: For a mux source whose forward bit is clear, the direct output stays low and the source acts through its enable bit, its status bit and the selected group's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| reg_valid_i | input | 1 | One-cycle register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 1 | Word address: 0 enable, 1 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| grp_irq_o | output | NUM_GRP | Registered grouped outputs to the parent |
| direct_irq_o | output | NUM_MUX | Bypass outputs of the muxed sources |

## Verification
The assertions assume that the source lines and the register strobe are steady at each rising edge. They also assume that a write and a read never coincide, because one strobe carries one access. The bench changes every input only at the falling edge and issues at most one access per cycle, so it stays within those assumptions. It drives random source patterns and random accesses that always use a legal word address. Directed steps add unconnected-only sources, a status write, and a second instance with a different forward mask.

// File: rtl/l2ia_pkg.sv
package l2ia_pkg;
   localparam int WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;
   typedef enum logic {
      ADDR_ENABLE = 1'b0,
      ADDR_STATUS = 1'b1
   } l2ia_addr_e;
endpackage

// File: rtl/l2ia_regs.sv
module l2ia_regs
   import l2ia_pkg::*;
#(
   parameter word_t CONN_MASK = 32'h0000_0FF8
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  valid_i,
   input  logic  write_i,
   input  logic  addr_i,
   input  word_t wdata_i,
   input  word_t src_i,
   output word_t en_o,
   output word_t rdata_o
);
   word_t en_q, rdata_q;
   logic  is_en_wr, is_rd;

   assign is_en_wr = valid_i && write_i && (l2ia_addr_e'(addr_i) == ADDR_ENABLE);
   assign is_rd    = valid_i && !write_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q    <= '0;
         rdata_q <= '0;
      end else begin
         if (is_en_wr)
            en_q <= wdata_i & CONN_MASK;
         if (is_rd)
            rdata_q <= (l2ia_addr_e'(addr_i) == ADDR_STATUS) ? (src_i & CONN_MASK) : en_q;
      end
   end

   assign en_o    = en_q;
   assign rdata_o = rdata_q;

   assert_en_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_en_wr |=> (en_o == ($past(wdata_i) & CONN_MASK)));

   assert_status_write_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && write_i && addr_i) |=> $stable(en_o));

   assert_rdata_unconnected_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rdata_o & ~CONN_MASK) == '0);
endmodule

// File: rtl/l2ia_group.sv
module l2ia_group
   import l2ia_pkg::*;
#(
   parameter word_t MASK = 32'h0000_0EB8
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  word_t src_i,
   input  word_t en_i,
   output logic  irq_o
);
   logic irq_q;
   logic hit;

   assign hit = |(src_i & en_i & MASK);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= hit;
   end

   assign irq_o = irq_q;

   // A raised output needs a member source high and a member enable set one cycle earlier (R5, R6)
   assert_grp_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> (($past(src_i) & MASK) != '0) && (($past(en_i) & MASK) != '0));

   assert_grp_nomask_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((src_i & MASK) == '0) |=> !irq_o);
endmodule

// File: rtl/l2ia_bypass.sv
module l2ia_bypass #(
   parameter int           NUM_MUX = 3,
   parameter logic [31:0]  FWD     = 32'h7
) (
   input  logic [NUM_MUX-1:0] src_i,
   output logic [NUM_MUX-1:0] direct_o
);
   for (genvar i = 0; i < NUM_MUX; i++) begin : g_mux
      if (FWD[i]) begin : g_fwd
         assign direct_o[i] = src_i[i];
      end else begin : g_held
         assign direct_o[i] = 1'b0;
      end
   end

   always_comb begin
      for (int i = 0; i < NUM_MUX; i++) begin
         if (!FWD[i])
            assert_unforwarded_low_R9: assert (direct_o[i] == 1'b0);
      end
   end
endmodule

// File: rtl/l2_irq_aggregator.sv
module l2_irq_aggregator
   import l2ia_pkg::*;
#(
   parameter int                          NUM_GRP   = 2,
   parameter logic [NUM_GRP-1:0][31:0]    GRP_MASKS = {32'h0000_0140, 32'h0000_0EB8},
   parameter int                          NUM_MUX   = 3,
   parameter logic [31:0]                 FWD_MASK  = 32'h0000_0007,
   parameter int                          MUX_GRP   = 0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [31:0]        src_i,
   input  logic               reg_valid_i,
   input  logic               reg_write_i,
   input  logic               reg_addr_i,
   input  logic [31:0]        reg_wdata_i,
   output logic [31:0]        reg_rdata_o,
   output logic [NUM_GRP-1:0] grp_irq_o,
   output logic [NUM_MUX-1:0] direct_irq_o
);
   localparam word_t MUX_BITS = word_t'((64'd1 << NUM_MUX) - 64'd1);
   localparam word_t FWD_ON   = FWD_MASK & MUX_BITS;
   localparam word_t MUX_BACK = MUX_BITS & ~FWD_MASK;

   function automatic word_t eff_mask(int g);
      word_t m;
      m = GRP_MASKS[g] & ~FWD_ON;
      if (g == MUX_GRP) m = m | MUX_BACK;
      return m;
   endfunction

   function automatic word_t conn_mask();
      word_t m;
      m = '0;
      for (int g = 0; g < NUM_GRP; g++) m = m | eff_mask(g);
      return m;
   endfunction

   localparam word_t CONN = conn_mask();

   initial begin
      assert_param_mux_R7: assert (NUM_MUX >= 1 && NUM_MUX <= WORD_W);
      assert_param_grp_R5: assert (NUM_GRP >= 1 && MUX_GRP >= 0 && MUX_GRP < NUM_GRP);
   end

   word_t en_w;

   l2ia_regs #(.CONN_MASK(CONN)) regs_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (reg_valid_i),
      .write_i (reg_write_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .src_i   (src_i),
      .en_o    (en_w),
      .rdata_o (reg_rdata_o)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      l2ia_group #(.MASK(eff_mask(g))) grp_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .src_i  (src_i),
         .en_i   (en_w),
         .irq_o  (grp_irq_o[g])
      );
   end

   l2ia_bypass #(.NUM_MUX(NUM_MUX), .FWD(FWD_MASK)) byp_i (
      .src_i    (src_i[NUM_MUX-1:0]),
      .direct_o (direct_irq_o)
   );

   always_comb begin
      for (int i = 0; i < NUM_MUX; i++) begin
         if (FWD_ON[i])
            assert_bypass_follow_R7: assert (direct_irq_o[i] == src_i[i]);
      end
   end

   assert_enable_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_w & ~CONN) == '0);
endmodule

// File: tb/l2_irq_aggregator_tb_top.sv
module l2_irq_aggregator_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        valid = 1'b0, write = 1'b0, addr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata1, rdata2;
   logic [1:0]  grp1, grp2;
   logic [2:0]  dir1, dir2;

   int checks = 0;
   int errors = 0;
   logic [31:0] en_m1 = '0, en_m2 = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   l2_irq_aggregator dut_i (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src),
      .reg_valid_i(valid), .reg_write_i(write), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata1), .grp_irq_o(grp1), .direct_irq_o(dir1));

   l2_irq_aggregator #(.FWD_MASK(32'h5)) dut2_i (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src),
      .reg_valid_i(valid), .reg_write_i(write), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata2), .grp_irq_o(grp2), .direct_irq_o(dir2));

   function automatic logic [31:0] conn_of(logic [31:0] fwd);
      return 32'hEB8 | 32'h140 | (~fwd & 32'h7);
   endfunction
   function automatic logic [31:0] g0_of(logic [31:0] fwd);
      return 32'hEB8 | (~fwd & 32'h7);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: drive at falling edge, check bypass, then check registered results one edge later
   task automatic cycle(logic [31:0] s, logic v, logic w, logic a, logic [31:0] d);
      logic [31:0] e1, e2;
      src = s; valid = v; write = w; addr = a; wdata = d;
      #1;
      chk("R7 direct", {29'd0, dir1}, {29'd0, s[2:0]});
      chk("R9 direct", {29'd0, dir2}, {29'd0, s[2] , 1'b0, s[0]});
      e1 = en_m1; e2 = en_m2;
      @(negedge clk);
      chk("R5 grp0", {31'd0, grp1[0]}, {31'd0, |(s & e1 & g0_of(32'h7))});
      chk("R6 grp1", {31'd0, grp1[1]}, {31'd0, |(s & e1 & 32'h140)});
      chk("R9 grp0", {31'd0, grp2[0]}, {31'd0, |(s & e2 & g0_of(32'h5))});
      if (v && !w) begin
         if (a) begin
            chk("R3 status", rdata1, s & conn_of(32'h7));
            chk("R9 status", rdata2, s & conn_of(32'h5));
         end else begin
            chk("R2 enable", rdata1, e1);
            chk("R2 enable2", rdata2, e2);
         end
      end
      if (v && w && !a) begin
         en_m1 = d & conn_of(32'h7);
         en_m2 = d & conn_of(32'h5);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 rdata", rdata1, 32'h0);
      chk("R1 grp", {30'd0, grp1}, 32'h0);
      cycle(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, '0);
      chk("R1 enable", rdata1, 32'h0);
      cycle('0, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF);
      cycle('0, 1'b1, 1'b0, 1'b0, '0);
      chk("R2 readback", rdata1, 32'h0000_0FF8);
      chk("R2 readback2", rdata2, 32'h0000_0FFA);
      // unconnected sources only, with every enable bit written
      cycle(32'hFFFF_F000, 1'b1, 1'b0, 1'b1, '0);
      chk("R8 status", rdata1, 32'h0);
      cycle(32'hFFFF_F000, 1'b0, 1'b0, 1'b0, '0);
      chk("R8 grp", {30'd0, grp1}, 32'h0);
      // status write must not alter enable
      cycle('0, 1'b1, 1'b1, 1'b1, 32'h0);
      cycle('0, 1'b1, 1'b0, 1'b0, '0);
      chk("R4 enable kept", rdata1, 32'h0000_0FF8);
      // un-forwarded mux source 1 in the second instance
      cycle(32'h2, 1'b1, 1'b0, 1'b1, '0);
      chk("R9 grp0 src1", {31'd0, grp2[0]}, 32'h1);
      chk("R9 status src1", rdata2, 32'h2);
      chk("R7 status fwd", rdata1, 32'h0);
      cycle(32'h7, 1'b1, 1'b1, 1'b0, 32'h0);
      cycle(32'h7, 1'b0, 1'b0, 1'b0, '0);
      chk("R7 grp0 fwd", {31'd0, grp1[0]}, 32'h0);
      for (int k = 0; k < 400; k++) begin
         logic [31:0] s, d;
         int op;
         s  = $urandom & ($urandom | 32'hFFFF_0000);
         d  = $urandom;
         op = $urandom_range(0, 9);
         case (op)
            0, 1, 2: cycle(s, 1'b1, 1'b1, 1'b0, d);
            3, 4:    cycle(s, 1'b1, 1'b0, 1'b0, '0);
            5, 6:    cycle(s, 1'b1, 1'b0, 1'b1, '0);
            7:       cycle(s, 1'b1, 1'b1, 1'b1, d);
            default: cycle(s, 1'b0, 1'b0, 1'b0, '0);
         endcase
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule